// File: doc/BRIEF.md
# Byte-Stream Debug Instruction Engine

This block sits behind a serial debug physical layer and turns a stream of command and operand bytes into accesses on an internal byte-wide bus. Each command byte selects one of eight operations: a load or store at an address carried in the operands, a load or store through an internal pointer, an access to a small local control register file, the capture of an eight-byte unlock key, or the loading of a repeat counter that makes the following command run several times.

Wide addresses and wide data are always moved one byte per bus cycle at consecutive addresses, least significant byte first. The pointer can advance after every byte, so a repeated pointer command walks through memory without any further address bytes. Read-back bytes leave on an output byte stream, one cycle after the bus returns them.

Top module: `dbg_instr_engine`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o, bus_rd_o, bus_wr_o and key_ok_o are 0.
- R2: Command bits [7:5] select the operation: 000 direct load, 001 direct store, 010 pointer load, 011 pointer store, 100 register load, 101 register store, 110 key, 111 repeat. For direct commands bits [3:2] hold the address byte count minus one and bits [1:0] the data byte count minus one; address bytes arrive least significant first and all of them are taken before any bus cycle starts.
- R3: A direct load of N bytes at address A performs N single-byte bus reads at A, A+1, ... and sends each byte on the output stream, in that order, one cycle after bus_ready_i.
- R4: A direct store takes each data byte from the input and writes it at A+i; a bus strobe stays high with stable address and data until bus_ready_i.
- R5: For pointer loads and stores, bits [1:0] give the byte count minus one; mode bits [3:2]=00 accesses pointer+i and leaves the pointer unchanged, 01 accesses the pointer and adds one to it after every byte.
- R6: Pointer mode bits [3:2]=1x accesses the 32-bit pointer itself: a load returns its lowest [1:0]+1 bytes least significant first, a store replaces those bytes and keeps the upper ones; no bus cycle occurs.
- R7: Register load and store move exactly one byte of the register indexed by bits [3:0]; index 0 reads the key status in bit 0 with zeros above, and writes to it are ignored.
- R8: A repeat command takes [1:0]+1 count bytes, least significant first, zero-extended to 32 bits; the next command byte is sent once and its operation runs count+1 times, with its operands sent for every run; a count of 0 runs it once.
- R9: A key command takes eight bytes, the first one landing in the lowest byte; key_ok_o becomes 1 when the result equals KEY_VALUE and 0 on any mismatch.
- R10: When a post-incrementing pointer access ends one repeated run, the next run starts in the same cycle and uses the already incremented pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input command or operand byte |
| in_ready_o | output | 1 | Engine accepts an input byte |
| out_valid_o | output | 1 | Read-back byte valid, one cycle |
| out_data_o | output | 8 | Read-back byte |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_ready_i | input | 1 | Bus access completes |
| key_ok_o | output | 1 | Unlock key matched |

## Verification
Completion of the last byte of a repeated command and the restart of its next run share one clock edge, and when the command post-increments the pointer, the pointer update and the relaunch also land on that edge. The bench provokes this with a repeat count of two followed by a one-byte post-incrementing pointer load from a known pointer, against a bus that inserts a wait cycle. It judges the result by the three returned bytes, which must come from three consecutive addresses, and by reading the pointer back afterwards, which must have moved by exactly three.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    OP_LDS  = 3'd0,
    OP_STS  = 3'd1,
    OP_LD   = 3'd2,
    OP_ST   = 3'd3,
    OP_LDCS = 3'd4,
    OP_STCS = 3'd5,
    OP_KEY  = 3'd6,
    OP_REP  = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    S_OP, S_ADDR, S_RD, S_WDATA, S_WR, S_PRD, S_PTRW,
    S_CSRR, S_CSRW, S_KEY, S_REPN
  } st_e;
endpackage

// File: rtl/dbg_key_check.sv
module dbg_key_check #(
  parameter int KEY_BYTES = 8,
  parameter logic [8*KEY_BYTES-1:0] KEY_VALUE = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       last_o,
  output logic       key_ok_o
);
  localparam int KW = 8 * KEY_BYTES;
  localparam int CW = $clog2(KEY_BYTES);

  logic [CW-1:0] cnt_q;
  logic [KW-1:0] sh_q, sh_nxt;

  assign last_o = (cnt_q == CW'(KEY_BYTES - 1));
  assign sh_nxt = {byte_i, sh_q[KW-1:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      key_ok_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (byte_valid_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      if (last_o) key_ok_o <= (sh_nxt == KEY_VALUE);
    end
  end

  // R9
  key_ok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && last_o) |=> $stable(key_ok_o));
endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             key_ok_i,
  output logic [7:0]       rdata_o
);
  localparam int NREG = 1 << IDX_W;

  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_status
      assign regs[g] = {7'b0, key_ok_i};
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          regs[g] <= '0;
        else if (we_i && idx_i == IDX_W'(g))  regs[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = regs[idx_i];
endmodule

// File: rtl/dbg_instr_engine.sv
module dbg_instr_engine
  import dbg_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CSR_IDX_W = 4,
  parameter int KEY_BYTES = 8,
  parameter logic [8*KEY_BYTES-1:0] KEY_VALUE = 64'h1289_AB45_CDD8_88FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [7:0]    out_data_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  input  logic          bus_ready_i,
  output logic          key_ok_o
);
  localparam int PW = 32;

  st_e         state_q, first_st;
  op_e         kind_q, dec_kind;
  logic [3:0]  fld_q, dec_fld;
  logic [1:0]  cnt_q;
  logic [PW-1:0] addr_q, ptr_q, rep_q;
  logic [PW-1:0] addr_nxt, ptr_nxt, rep_nxt, base, bus_addr_full;
  logic [7:0]  wdata_q, csr_rdata;
  logic        in_fire, ind, postinc, last_d, finish, launch, relaunch;
  logic        key_last;

  // opcode comes from the stream in S_OP, else from the held copy (repeat)
  assign dec_kind = (state_q == S_OP) ? op_e'(in_data_i[7:5]) : kind_q;
  assign dec_fld  = (state_q == S_OP) ? in_data_i[3:0]        : fld_q;

  always_comb begin
    unique case (dec_kind)
      OP_LDS, OP_STS: first_st = S_ADDR;
      OP_LD:   first_st = dec_fld[3] ? S_PRD  : S_RD;
      OP_ST:   first_st = dec_fld[3] ? S_PTRW : S_WDATA;
      OP_LDCS: first_st = S_CSRR;
      OP_STCS: first_st = S_CSRW;
      OP_KEY:  first_st = S_KEY;
      default: first_st = S_REPN;
    endcase
  end

  assign in_ready_o = state_q inside {S_OP, S_ADDR, S_WDATA, S_PTRW, S_CSRW, S_KEY, S_REPN};
  assign in_fire    = in_valid_i && in_ready_o;
  assign ind        = (kind_q == OP_LD) || (kind_q == OP_ST);
  assign postinc    = ind && (fld_q[3:2] == 2'b01);
  assign last_d     = (cnt_q == fld_q[1:0]);

  assign base          = ind ? ptr_q : addr_q;
  assign bus_addr_full = base + (postinc ? '0 : PW'(cnt_q));
  assign bus_addr_o    = bus_addr_full[AW-1:0];
  assign bus_rd_o      = (state_q == S_RD);
  assign bus_wr_o      = (state_q == S_WR);
  assign bus_wdata_o   = wdata_q;

  always_comb begin
    addr_nxt = addr_q;
    ptr_nxt  = ptr_q;
    rep_nxt  = rep_q;
    addr_nxt[8*cnt_q +: 8] = in_data_i;
    ptr_nxt[8*cnt_q +: 8]  = in_data_i;
    rep_nxt[8*cnt_q +: 8]  = in_data_i;
  end

  always_comb begin
    unique case (state_q)
      S_RD, S_WR: finish = bus_ready_i && last_d;
      S_PRD:      finish = last_d;
      S_PTRW:     finish = in_fire && last_d;
      S_CSRR:     finish = 1'b1;
      S_CSRW:     finish = in_fire;
      S_KEY:      finish = in_fire && key_last;
      default:    finish = 1'b0;
    endcase
  end

  assign relaunch = finish && (rep_q != '0);
  assign launch   = ((state_q == S_OP) && in_fire) || relaunch;

  dbg_key_check #(.KEY_BYTES(KEY_BYTES), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk_i, .rst_ni,
    .start_i     (launch && dec_kind == OP_KEY),
    .byte_valid_i(state_q == S_KEY && in_fire),
    .byte_i      (in_data_i),
    .last_o      (key_last),
    .key_ok_o
  );

  dbg_csr_file #(.IDX_W(CSR_IDX_W)) u_csr (
    .clk_i, .rst_ni,
    .we_i    (state_q == S_CSRW && in_fire),
    .idx_i   (fld_q[CSR_IDX_W-1:0]),
    .wdata_i (in_data_i),
    .key_ok_i(key_ok_o),
    .rdata_o (csr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_OP;
      kind_q      <= OP_LDS;
      fld_q       <= '0;
      cnt_q       <= '0;
      addr_q      <= '0;
      ptr_q       <= '0;
      rep_q       <= '0;
      wdata_q     <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        S_ADDR: if (in_fire) begin
          addr_q <= addr_nxt;
          if (cnt_q == fld_q[3:2]) begin
            cnt_q   <= '0;
            state_q <= (kind_q == OP_LDS) ? S_RD : S_WDATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_RD: if (bus_ready_i) begin
          out_valid_o <= 1'b1;
          out_data_o  <= bus_rdata_i;
          if (postinc) ptr_q <= ptr_q + 1'b1;
          if (!last_d) cnt_q <= cnt_q + 1'b1;
        end
        S_WDATA: if (in_fire) begin
          wdata_q <= in_data_i;
          state_q <= S_WR;
        end
        S_WR: if (bus_ready_i) begin
          if (postinc) ptr_q <= ptr_q + 1'b1;
          if (!last_d) begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= S_WDATA;
          end
        end
        S_PRD: begin
          out_valid_o <= 1'b1;
          out_data_o  <= ptr_q[8*cnt_q +: 8];
          if (!last_d) cnt_q <= cnt_q + 1'b1;
        end
        S_PTRW: if (in_fire) begin
          ptr_q <= ptr_nxt;
          if (!last_d) cnt_q <= cnt_q + 1'b1;
        end
        S_CSRR: begin
          out_valid_o <= 1'b1;
          out_data_o  <= csr_rdata;
        end
        S_REPN: if (in_fire) begin
          rep_q <= rep_nxt;
          if (last_d) state_q <= S_OP;
          else        cnt_q   <= cnt_q + 1'b1;
        end
        default: ;
      endcase

      if (finish) state_q <= S_OP;
      if (relaunch) rep_q <= rep_q - 1'b1;
      if (launch) begin
        kind_q  <= dec_kind;
        fld_q   <= dec_fld;
        cnt_q   <= '0;
        addr_q  <= '0;
        state_q <= first_st;
        if (dec_kind == OP_REP) rep_q <= '0;
      end
    end
  end

  // R4
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && !bus_ready_i) |=>
      (bus_rd_o == $past(bus_rd_o) && bus_wr_o == $past(bus_wr_o) &&
       $stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R4
  wr_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wr_o) |-> $past(in_valid_i && in_ready_o));

  // R3
  rd_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && bus_ready_i) |=> (out_valid_o && out_data_o == $past(bus_rdata_i)));

  // R8
  rep_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_REPN) |=> (rep_q <= $past(rep_q)));

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_PTRW) |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1));
endmodule

// File: tb/sim_dbg_instr_engine.sv
module sim_dbg_instr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, bus_rd, bus_wr, key_ok;
  logic [7:0]  out_data, bus_wdata, bus_rdata;
  logic [31:0] bus_addr;
  logic        bus_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  outs [1024];
  int          n_out = 0;
  int          n_bus = 0;
  logic [31:0] last_addr = '0;

  always #5 clk = ~clk;

  dbg_instr_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_ready_i(bus_ready),
    .key_ok_o(key_ok)
  );

  initial for (int i = 0; i < 256; i++) begin
    mem[i]     = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end

  // bus model: one wait cycle per access
  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) begin
    if (!rst_n) bus_ready <= 1'b0;
    else begin
      bus_ready <= (bus_rd || bus_wr) && !bus_ready;
      if ((bus_rd || bus_wr) && bus_ready) begin
        last_addr <= bus_addr;
        n_bus     <= n_bus + 1;
        if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
      end
    end
  end

  always @(negedge clk) if (out_valid && n_out < 1024) begin
    outs[n_out] <= out_data;
    n_out       <= n_out + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [31:0] p);
    send(8'h6B);
    for (int i = 0; i < 4; i++) send(p[8*i +: 8]);
    idle(2);
  endtask

  task automatic check_ptr(input string tag, input logic [31:0] exp);
    int b = n_out;
    send(8'h4B);
    idle(8);
    check(tag, {outs[b+3], outs[b+2], outs[b+1], outs[b]}, exp);
  endtask

  task automatic t_reset;
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 strobes", {30'b0, bus_rd, bus_wr}, 0);
    check("R1 key_ok", 32'(key_ok), 0);
  endtask

  task automatic t_direct;
    int b0 = n_bus;
    int b;
    send(8'h25);            // store, 2 addr bytes, 2 data bytes
    send(8'h10);
    idle(5);
    check("R2 no bus cycle before last address byte", n_bus - b0, 0);
    send(8'h00);
    send(8'hA1);
    send(8'hB2);
    idle(6);
    exp_mem[8'h10] = 8'hA1;
    exp_mem[8'h11] = 8'hB2;
    check("R4 store byte0", mem[8'h10], 8'hA1);
    check("R4 store byte1", mem[8'h11], 8'hB2);
    check("R4 store bus cycles", n_bus - b0, 2);
    b = n_out;
    send(8'h01);            // load, 1 addr byte, 2 data bytes
    send(8'h10);
    idle(10);
    check("R3 load count", n_out - b, 2);
    check("R3 load byte0", outs[b], exp_mem[8'h10]);
    check("R3 load byte1", outs[b+1], exp_mem[8'h11]);
    b = n_out;
    send(8'h0C);            // load, 4 addr bytes, 1 data byte
    send(8'h44); send(8'h33); send(8'h22); send(8'h11);
    idle(8);
    check("R2 four-byte address", last_addr, 32'h1122_3344);
    check("R3 load far byte", outs[b], exp_mem[8'h44]);
  endtask

  task automatic t_pointer;
    int b;
    set_ptr(32'h0001_0020);
    check_ptr("R6 pointer readback", 32'h0001_0020);
    send(8'h68); send(8'h40);   // replace lowest pointer byte only
    idle(2);
    check_ptr("R6 partial pointer write", 32'h0001_0040);
    set_ptr(32'h0000_0020);
    send(8'h64); send(8'h55);   // post-increment store, 1 byte
    idle(6);
    exp_mem[8'h20] = 8'h55;
    check("R5 post-inc store", mem[8'h20], 8'h55);
    check_ptr("R5 pointer advanced", 32'h21);
    send(8'h61); send(8'h66); send(8'h77);  // plain indirect, 2 bytes
    idle(6);
    exp_mem[8'h21] = 8'h66;
    exp_mem[8'h22] = 8'h77;
    check("R5 indirect byte0", mem[8'h21], 8'h66);
    check("R5 indirect byte1", mem[8'h22], 8'h77);
    check_ptr("R5 pointer unchanged", 32'h21);
    b = n_out;
    send(8'h45);                // post-increment load, 2 bytes
    idle(10);
    check("R5 post-inc load byte0", outs[b], exp_mem[8'h21]);
    check("R5 post-inc load byte1", outs[b+1], exp_mem[8'h22]);
    check_ptr("R5 pointer after load", 32'h23);
  endtask

  task automatic t_csr;
    int b;
    send(8'hA3); send(8'h9C);
    send(8'hA0); send(8'hFF);
    b = n_out;
    send(8'h83);
    idle(3);
    send(8'h80);
    idle(3);
    check("R7 register 3 readback", outs[b], 8'h9C);
    check("R7 register 0 ignores write", outs[b+1], 8'h00);
  endtask

  task automatic send_key(input logic [63:0] k);
    send(8'hC0);
    for (int i = 0; i < 8; i++) send(k[8*i +: 8]);
    idle(2);
  endtask

  task automatic t_key;
    int b;
    send_key(64'h1289_AB45_CDD8_88FE);
    check("R9 wrong key", 32'(key_ok), 0);
    send_key(64'h1289_AB45_CDD8_88FF);
    check("R9 right key", 32'(key_ok), 1);
    b = n_out;
    send(8'h80);
    idle(3);
    check("R7 status bit", outs[b], 8'h01);
    send_key(64'h0289_AB45_CDD8_88FF);
    check("R9 mismatch clears", 32'(key_ok), 0);
  endtask

  task automatic t_repeat;
    int b;
    set_ptr(32'h10);
    send(8'hE0); send(8'h02);   // count 2 -> three runs
    b = n_out;
    send(8'h44);                // post-increment load, 1 byte
    idle(16);
    check("R10 run count", n_out - b, 3);
    check("R10 run0", outs[b],   exp_mem[8'h10]);
    check("R10 run1", outs[b+1], exp_mem[8'h11]);
    check("R10 run2", outs[b+2], exp_mem[8'h12]);
    check_ptr("R10 pointer after runs", 32'h13);
    send(8'hE1); send(8'h02); send(8'h00);  // two count bytes
    send(8'h20);
    send(8'h30); send(8'hC1);
    send(8'h31); send(8'hC2);
    send(8'h32); send(8'hC3);
    idle(6);
    check("R8 repeated store 0", mem[8'h30], 8'hC1);
    check("R8 repeated store 1", mem[8'h31], 8'hC2);
    check("R8 repeated store 2", mem[8'h32], 8'hC3);
    send(8'hE0); send(8'h00);   // count 0 -> one run
    send(8'h64); send(8'h99);
    idle(6);
    check("R8 count zero store", mem[8'h13], 8'h99);
    check_ptr("R8 count zero runs once", 32'h14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_direct();
    t_pointer();
    t_csr();
    t_key();
    t_repeat();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule